// File: doc/BRIEF.md
# Indirect Register-Access Bus Bridge

The bridge gives a host that can only reach three 64-bit registers a way to perform single reads and writes on a 32-bit on-chip bus. The host fills a data register and then writes a command word to the control register. That write starts one downstream access of 1, 2 or 4 bytes. The host then polls the status register until the done flag appears. The status word reports the read result, the error code the bus returned, a malformed-command flag and a timeout flag. A nonzero error field seen together with done means the transaction failed.

All words use MSB-first numbering: field bit n sits at vector index 63-n. Data moves left-justified in both directions. Write data comes from the top bytes of the data register. Read data is placed at the top of the 32-bit read field.

Downstream, the bridge drives a plain request/acknowledge port. The request is held until either an acknowledge arrives or a programmable number of wait cycles runs out. A timeout aborts the access.

Top module: `indirect_bus_bridge`

## Requirements
- R1: After synchronous reset, bus_req is 0 and the status, control and data registers all read as zero.
- R2: A host write to offset 0 is a valid command when index [63:60] equals 4'hD and the byte count in [59:56] is 1, 2 or 4. In the cycle after that write, the bridge asserts bus_req with these values: bus_addr from [31:0], bus_size equal to the byte count, and bus_we equal to the inverse of the read bit at index [48]. The values stay stable while the request is held.
- R3: For a downstream write, bus_wdata carries the top bytes of the data register (offset 3), right-justified. One byte comes from [63:56], two bytes from [63:48] and four bytes from [63:32].
- R4: Status busy (index [19]) reads 1 from the cycle after a valid command until the access completes. Busy always equals bus_req, and it is never set together with done.
- R5: The cycle after bus_ack is sampled high during a request, busy clears and done (index [11]) sets. The 6-bit bus_err value is captured into status [63:58].
- R6: The bus_rdata of a read is stored left-justified in status [57:26]. A 1-byte result fills [57:50] from bus_rdata[7:0], and a 2-byte result fills [57:42] from bus_rdata[15:0]. After a write access, this field reads zero.
- R7: A command whose byte count is not 1, 2 or 4, or whose [63:60] is not 4'hD, never raises bus_req. It shows done and the bad-command flag (index [18]) from the next cycle.
- R8: If no acknowledge arrives, bus_req stays high for exactly tmo_limit+1 cycles and then drops. Done and the timeout flag (index [17]) are then set.
- R9: An accepted control write clears done, the error code, both error flags and the read field before the new access.
- R10: A control write while busy is ignored: the pending bus_addr and the stored control word stay unchanged.
- R11: Reads are registered, so reg_rdata shows the word for reg_addr one cycle later. Offset 0 returns the last accepted control word, offset 2 the status word, offset 3 the data register, and offset 1 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register offset for read and write |
| reg_wdata | input | 64 | Host write data |
| reg_rdata | output | 64 | Registered host read data |
| tmo_limit | input | TMO_W | Wait cycles allowed before a downstream abort |
| bus_req | output | 1 | Downstream request, held until acknowledge or abort |
| bus_we | output | 1 | Downstream direction, 1 for write |
| bus_addr | output | 32 | Downstream byte address |
| bus_size | output | 3 | Downstream transfer size in bytes |
| bus_wdata | output | 32 | Downstream write data, right-justified |
| bus_ack | input | 1 | Downstream acknowledge |
| bus_rdata | input | 32 | Downstream read data, right-justified |
| bus_err | input | 6 | Downstream error code, sampled with bus_ack |

## Verification
The checker assumes two things about the inputs. First, tmo_limit is held constant while a request is outstanding, because the bounded-wait property compares a running count against its live value. Second, bus_ack is only meaningful while bus_req is high. The stimulus meets both conditions: it sets tmo_limit once before any access and raises the acknowledge only during a request, for a single cycle. The stimulus also keeps host writes one cycle wide, so every accepted command can be traced to exactly one start.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
  localparam int WORD_W = 64;
  localparam int BUS_AW = 32;
  localparam int BUS_DW = 32;
  localparam int ERR_W  = 6;

  localparam logic [3:0] CTL_KEY = 4'hD;

  // Control word fields (vector indices, MSB-0 bit n maps to 63-n)
  localparam int CTL_KEY_HI = 63;
  localparam int CTL_KEY_LO = 60;
  localparam int CTL_SZ_HI  = 59;
  localparam int CTL_SZ_LO  = 56;
  localparam int CTL_RD     = 48;

  // Status word fields
  localparam int ST_ERR_HI = 63;
  localparam int ST_ERR_LO = 58;
  localparam int ST_RD_HI  = 57;
  localparam int ST_RD_LO  = 26;
  localparam int ST_BUSY   = 19;
  localparam int ST_BADCMD = 18;
  localparam int ST_TMO    = 17;
  localparam int ST_DONE   = 11;

  localparam logic [1:0] OFS_CTL  = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;

  typedef struct packed {
    logic [BUS_AW-1:0] addr;
    logic [2:0]        nbytes;
    logic              rd;
  } ixb_cmd_t;
endpackage

// File: rtl/ixb_cmd_decode.sv
module ixb_cmd_decode
  import ixb_pkg::*;
(
  input  logic [3:0]        key,
  input  logic [3:0]        size_f,
  input  logic              rd_f,
  input  logic [BUS_AW-1:0] addr_f,
  input  logic [BUS_DW-1:0] data_top,
  output ixb_cmd_t          cmd,
  output logic              cmd_ok,
  output logic [BUS_DW-1:0] wdata
);
  logic size_ok;

  always_comb begin
    size_ok    = (size_f == 4'd1) || (size_f == 4'd2) || (size_f == 4'd4);
    cmd_ok     = size_ok && (key == CTL_KEY);
    cmd.addr   = addr_f;
    cmd.nbytes = size_f[2:0];
    cmd.rd     = rd_f;
    case (size_f[2:0])
      3'd1:    wdata = {{(BUS_DW-8){1'b0}}, data_top[BUS_DW-1 -: 8]};
      3'd2:    wdata = {{(BUS_DW-16){1'b0}}, data_top[BUS_DW-1 -: 16]};
      default: wdata = data_top;
    endcase
  end
endmodule

// File: rtl/ixb_bus_engine.sv
module ixb_bus_engine
  import ixb_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  ixb_cmd_t          cmd,
  input  logic [BUS_DW-1:0] wdata,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [2:0]        bus_size,
  output logic [BUS_DW-1:0] bus_wdata,
  output logic              fin_ok,
  output logic              fin_tmo
);
  logic [TMO_W-1:0] wait_cnt;
  logic             at_limit;

  assign at_limit = (wait_cnt == tmo_limit);
  assign fin_ok   = bus_req && bus_ack;
  assign fin_tmo  = bus_req && !bus_ack && at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
      wait_cnt  <= '0;
    end else if (start) begin
      bus_req   <= 1'b1;
      bus_we    <= !cmd.rd;
      bus_addr  <= cmd.addr;
      bus_size  <= cmd.nbytes;
      bus_wdata <= wdata;
      wait_cnt  <= '0;
    end else if (bus_req) begin
      if (fin_ok || fin_tmo) begin
        bus_req <= 1'b0;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ixb_status_pack.sv
module ixb_status_pack
  import ixb_pkg::*;
(
  input  logic [ERR_W-1:0]  errc,
  input  logic [BUS_DW-1:0] rd_raw,
  input  logic [2:0]        rd_nbytes,
  input  logic              busy,
  input  logic              bad,
  input  logic              tmo,
  input  logic              done,
  output logic [WORD_W-1:0] stat
);
  logic [BUS_DW-1:0] rd_just;

  always_comb begin
    case (rd_nbytes)
      3'd1:    rd_just = {rd_raw[7:0],  {(BUS_DW-8){1'b0}}};
      3'd2:    rd_just = {rd_raw[15:0], {(BUS_DW-16){1'b0}}};
      default: rd_just = rd_raw;
    endcase
    stat                       = '0;
    stat[ST_ERR_HI:ST_ERR_LO]  = errc;
    stat[ST_RD_HI:ST_RD_LO]    = rd_just;
    stat[ST_BUSY]              = busy;
    stat[ST_BADCMD]            = bad;
    stat[ST_TMO]               = tmo;
    stat[ST_DONE]              = done;
  end
endmodule

// File: rtl/indirect_bus_bridge.sv
module indirect_bus_bridge
  import ixb_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              bus_req,
  output logic              bus_we,
  output logic [31:0]       bus_addr,
  output logic [2:0]        bus_size,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  input  logic [5:0]        bus_err
);
  logic [WORD_W-1:0] ctl_q, data_q, stat_w;
  logic              busy_q, done_q, bad_q, tmo_q, rdop_q;
  logic [ERR_W-1:0]  errc_q;
  logic [BUS_DW-1:0] rd_raw_q;
  logic [2:0]        rd_nb_q;

  ixb_cmd_t          cmd;
  logic              cmd_ok;
  logic [BUS_DW-1:0] cmd_wdata;
  logic              ctl_wr, accept, start, reject;
  logic              fin_ok, fin_tmo;

  ixb_cmd_decode u_dec (
    .key      (reg_wdata[CTL_KEY_HI:CTL_KEY_LO]),
    .size_f   (reg_wdata[CTL_SZ_HI:CTL_SZ_LO]),
    .rd_f     (reg_wdata[CTL_RD]),
    .addr_f   (reg_wdata[BUS_AW-1:0]),
    .data_top (data_q[WORD_W-1 -: BUS_DW]),
    .cmd      (cmd),
    .cmd_ok   (cmd_ok),
    .wdata    (cmd_wdata)
  );

  assign ctl_wr = reg_wr && (reg_addr == OFS_CTL);
  assign accept = ctl_wr && !busy_q;
  assign start  = accept && cmd_ok;
  assign reject = accept && !cmd_ok;

  ixb_bus_engine #(.TMO_W(TMO_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd       (cmd),
    .wdata     (cmd_wdata),
    .tmo_limit (tmo_limit),
    .bus_ack   (bus_ack),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .fin_ok    (fin_ok),
    .fin_tmo   (fin_tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      data_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      bad_q    <= 1'b0;
      tmo_q    <= 1'b0;
      rdop_q   <= 1'b0;
      errc_q   <= '0;
      rd_raw_q <= '0;
      rd_nb_q  <= 3'd4;
    end else begin
      if (reg_wr && (reg_addr == OFS_DATA)) data_q <= reg_wdata;
      if (accept) begin
        ctl_q    <= reg_wdata;
        busy_q   <= start;
        done_q   <= reject;
        bad_q    <= reject;
        tmo_q    <= 1'b0;
        errc_q   <= '0;
        rd_raw_q <= '0;
        rd_nb_q  <= cmd.nbytes;
        rdop_q   <= cmd.rd;
      end else if (fin_ok) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        errc_q <= bus_err;
        if (rdop_q) rd_raw_q <= bus_rdata;
      end else if (fin_tmo) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        tmo_q  <= 1'b1;
      end
    end
  end

  ixb_status_pack u_pack (
    .errc      (errc_q),
    .rd_raw    (rd_raw_q),
    .rd_nbytes (rd_nb_q),
    .busy      (busy_q),
    .bad       (bad_q),
    .tmo       (tmo_q),
    .done      (done_q),
    .stat      (stat_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        OFS_CTL:  reg_rdata <= ctl_q;
        OFS_STAT: reg_rdata <= stat_w;
        OFS_DATA: reg_rdata <= data_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ixb_bridge_chk.sv
module ixb_bridge_chk #(
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_ack,
  input logic             bus_we,
  input logic [31:0]      bus_addr,
  input logic [2:0]       bus_size,
  input logic [TMO_W-1:0] tmo_limit,
  input logic             st_busy,
  input logic             st_done,
  input logic             st_bad
);
  logic [TMO_W:0] req_run;

  always_ff @(posedge clk) begin
    if (rst)          req_run <= '0;
    else if (bus_req) req_run <= req_run + 1'b1;
    else              req_run <= '0;
  end

  p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(st_busy && st_done));

  p_req_tracks_busy_r4: assert property (@(posedge clk) disable iff (rst)
    bus_req == st_busy);

  p_ack_completes_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack) |=> (st_done && !st_busy));

  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (!bus_req ||
      ($stable(bus_addr) && $stable(bus_we) && $stable(bus_size))));

  p_bad_no_req_r7: assert property (@(posedge clk) disable iff (rst)
    st_bad |-> !bus_req);

  p_wait_bound_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (req_run <= {1'b0, tmo_limit}));
endmodule

bind indirect_bus_bridge ixb_bridge_chk #(.TMO_W(TMO_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .tmo_limit (tmo_limit),
  .st_busy   (stat_w[19]),
  .st_done   (stat_w[11]),
  .st_bad    (stat_w[18])
);

// File: tb/indirect_bus_bridge_tb.sv
module indirect_bus_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO_W      = 16;
  localparam int LIMIT      = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [63:0]      reg_wdata = '0;
  logic [63:0]      reg_rdata;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic             bus_req, bus_we;
  logic [31:0]      bus_addr, bus_wdata;
  logic [2:0]       bus_size;
  logic             bus_ack = 1'b0;
  logic [31:0]      bus_rdata = '0;
  logic [5:0]       bus_err = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  indirect_bus_bridge #(.TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmo_limit(tmo_limit),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ctl_word(logic [3:0] key, logic [3:0] sz,
                                           bit rd, logic [31:0] a);
    logic [63:0] v = '0;
    v[63:60] = key;
    v[59:56] = sz;
    v[48]    = rd;
    v[40:38] = 3'd4;
    v[31:0]  = a;
    return v;
  endfunction

  function automatic logic [63:0] exp_stat(logic [5:0] e, logic [31:0] rf,
                                           bit busy, bit bad, bit tmo, bit done);
    logic [63:0] v = '0;
    v[63:58] = e;
    v[57:26] = rf;
    v[19]    = busy;
    v[18]    = bad;
    v[17]    = tmo;
    v[11]    = done;
    return v;
  endfunction

  function automatic logic [31:0] left_just(logic [31:0] raw, int sz);
    logic [63:0] m = (64'd1 << (8*sz)) - 64'd1;
    return 32'(((64'(raw) & m) << (32 - 8*sz)));
  endfunction

  // All tasks start and end at a falling edge.
  task automatic host_write(logic [1:0] a, logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(logic [1:0] a, output logic [63:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic run_op(logic [3:0] key, int sz, bit rd, logic [31:0] a,
                        logic [63:0] dval, int lat);
    logic [63:0] st;
    logic [31:0] rsp;
    logic [5:0]  ev;
    bit ok;
    ok  = (key == 4'hD) && (sz == 1 || sz == 2 || sz == 4);
    rsp = 32'hA1B2_C3D4 ^ (32'(sz) * 32'h0101_0101) ^ 32'(rd);
    ev  = 6'((sz * 7 + int'(rd)) & 63);
    host_write(2'd0, ctl_word(key, 4'(sz), rd, a));
    if (ok) begin
      chk("R2 bus_req", 64'(bus_req), 64'd1);
      chk("R2 bus_addr", 64'(bus_addr), 64'(a));
      chk("R2 bus_we", 64'(bus_we), 64'(!rd));
      chk("R2 bus_size", 64'(bus_size), 64'(sz));
      if (!rd) chk("R3 bus_wdata", 64'(bus_wdata), 64'(32'(dval >> (64 - 8*sz))));
      repeat (lat) @(negedge clk);
      bus_ack = 1'b1; bus_rdata = rsp; bus_err = ev;
      @(negedge clk);
      bus_ack = 1'b0;
      chk("R5 bus_req dropped", 64'(bus_req), 64'd0);
      read_reg(2'd2, st);
      chk(rd ? "R6 R5 status read" : "R5 R6 status write", st,
          exp_stat(ev, rd ? left_just(rsp, sz) : 32'd0, 0, 0, 0, 1));
    end else begin
      chk("R7 no request", 64'(bus_req), 64'd0);
      read_reg(2'd2, st);
      chk("R7 status", st, exp_stat(6'd0, 32'd0, 0, 1, 0, 1));
    end
  endtask

  initial begin
    logic [63:0] v, dval;
    int n;
    tmo_limit = TMO_W'(LIMIT);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 bus_req", 64'(bus_req), 64'd0);
    read_reg(2'd2, v); chk("R1 status", v, 64'd0);
    read_reg(2'd0, v); chk("R1 control", v, 64'd0);
    read_reg(2'd3, v); chk("R1 data", v, 64'd0);

    // Sweep every size code in both directions
    for (int sz = 0; sz < 16; sz++) begin
      for (int rd = 0; rd < 2; rd++) begin
        dval = 64'h8C17_5AE3_29D0_F64B ^ (64'(sz) << 52) ^ (64'(rd) << 33);
        host_write(2'd3, dval);
        run_op(4'hD, sz, rd[0], 32'h4000_0000 + 32'(sz) * 32'h1111 + 32'(rd),
               dval, sz % 4);
      end
    end

    // R7 wrong key with legal size
    run_op(4'hC, 4, 1'b0, 32'h0000_1234, dval, 0);
    run_op(4'h5, 1, 1'b1, 32'h0000_5678, dval, 0);

    // R11 readback of data, control and unused offset
    read_reg(2'd3, v); chk("R11 data readback", v, dval);
    read_reg(2'd0, v); chk("R11 control readback", v,
                           ctl_word(4'h5, 4'd1, 1'b1, 32'h0000_5678));
    read_reg(2'd1, v); chk("R11 unused offset", v, 64'd0);

    // R8 timeout: no acknowledge
    host_write(2'd0, ctl_word(4'hD, 4'd4, 1'b1, 32'hDEAD_0000));
    n = 0;
    while (bus_req && n < 50) begin n++; @(negedge clk); end
    chk("R8 request cycles", 64'(n), 64'(LIMIT + 1));
    read_reg(2'd2, v); chk("R8 status", v, exp_stat(6'd0, 32'd0, 0, 0, 1, 1));

    // R9 new command clears flags; R4 busy while pending
    host_write(2'd0, ctl_word(4'hD, 4'd2, 1'b1, 32'h0000_00A0));
    read_reg(2'd2, v); chk("R9 R4 status pending", v, exp_stat(6'd0, 32'd0, 1, 0, 0, 0));

    // R10 control write while busy is ignored
    host_write(2'd0, ctl_word(4'hD, 4'd1, 1'b0, 32'h0000_00B0));
    chk("R10 address held", 64'(bus_addr), 64'h0000_00A0);
    bus_ack = 1'b1; bus_rdata = 32'h0000_BEEF; bus_err = 6'd0;
    @(negedge clk);
    bus_ack = 1'b0;
    read_reg(2'd2, v); chk("R6 halfword", v, exp_stat(6'd0, 32'hBEEF_0000, 0, 0, 0, 1));
    read_reg(2'd0, v); chk("R10 control unchanged", v,
                           ctl_word(4'hD, 4'd2, 1'b1, 32'h0000_00A0));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule